// File: doc/BRIEF.md
# Leaf Page Entry Access Checker

This block decides whether a memory access may go ahead once a translation walk has reached a leaf page table entry. It looks at the 64-bit entry and three attributes of the access: whether it is privileged, whether it is an instruction fetch, and whether it is a store. It returns exactly one of three results: access allowed, permission error, or reference/change error.

The block has two checks. The permission check reads the access-authority field and the memory-type field. The reference/change check reads the reference and change flags. A permission failure always wins over a reference/change failure. A parameter selects between two forms. In the registered form the result and a one-cycle done pulse appear on the cycle after the request strobe. In the combinational form they appear in the same cycle.

Top module: `pte_access_check`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, acc_ok, perm_err, rc_err and chk_done are 0 in the registered form, even if a request is presented during reset.
- R2: Entry bit 3 marks a privileged-only page. A non-privileged access (is_priv=0) to such a page gets perm_err. A privileged access is judged on the remaining authority bits.
- R3: For a data access (is_fetch=0), permission is granted when the write bit (bit 1) is set, or when the read bit (bit 2) is set and is_store=0.
- R4: For an instruction fetch (is_fetch=1), permission needs the execute bit (bit 0) set and memory-type bit 5 clear. Types 10 (non-idempotent) and 11 (tolerant I/O) in bits 5:4 refuse fetch, and types 00 and 01 do not. Bit 5 does not affect data accesses.
- R5: The reference/change check passes when the reference bit (bit 8) is set and either the change bit (bit 7) is set or is_store=0. It applies to fetches as well as data accesses.
- R6: When both checks fail, only perm_err is raised. rc_err is raised only when permission was granted.
- R7: When chk_done is 1, exactly one of acc_ok, perm_err and rc_err is 1. When chk_done is 0, all three are 0.
- R8: With REGISTER_OUT=1, the result and chk_done appear on the cycle after chk_valid and last exactly one cycle unless a new request follows. With REGISTER_OUT=0, they follow chk_valid in the same cycle.
- R9: Entry bits 63:9, bit 6 and bit 4 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_valid | input | 1 | Request strobe: the entry and attributes are valid this cycle |
| pte | input | ENTRY_W | Leaf page table entry |
| is_priv | input | 1 | Access is made in privileged state |
| is_fetch | input | 1 | Access is an instruction fetch |
| is_store | input | 1 | Access is a store |
| acc_ok | output | 1 | Access allowed |
| perm_err | output | 1 | Access refused by the authority or memory-type check |
| rc_err | output | 1 | Access refused by the reference/change check |
| chk_done | output | 1 | Result strobe |

## Verification
The bench builds two copies of the block side by side with ENTRY_W=64. One has REGISTER_OUT=1 and the other REGISTER_OUT=0, so both the one-cycle-late result with its done pulse and the same-cycle result are checked against the same vectors. Back-to-back requests check that the registered copy replaces each result on every cycle. Entries with all of the ignored high bits, bit 6 and bit 4 set show that those bits leave the result unchanged.

// File: rtl/pte_chk_pkg.sv
// Package: field positions within a leaf page table entry (bit 0 = LSB)
// and the verdict encoding shared by the checker's sub-blocks.
package pte_chk_pkg;
    localparam int AUTH_EXEC_BIT  = 0;   // execute granted
    localparam int AUTH_WRITE_BIT = 1;   // write (and read) granted
    localparam int AUTH_READ_BIT  = 2;   // read granted
    localparam int AUTH_PRIV_BIT  = 3;   // privileged-only page
    localparam int MTYPE_HI_BIT   = 5;   // set for non-idempotent / tolerant I/O
    localparam int CHG_BIT        = 7;   // change flag
    localparam int REF_BIT        = 8;   // reference flag
    localparam int MIN_ENTRY_W    = REF_BIT + 1;

    typedef enum logic [1:0] {
        VERD_OK   = 2'd0,
        VERD_PERM = 2'd1,
        VERD_RC   = 2'd2
    } verdict_t;
endpackage

// File: rtl/pte_perm_eval.sv
// Authority check: decides whether the access kind is allowed by the
// authority bits and memory type. Purely combinational; assumes the caller
// has already sliced the relevant entry bits.
module pte_perm_eval (
    input  logic [3:0] auth,      // bits 3:0 of the entry
    input  logic       io_type,   // bit 5 of the entry
    input  logic       is_priv,
    input  logic       is_fetch,
    input  logic       is_store,
    output logic       perm_ok
);
    import pte_chk_pkg::*;

    logic gate_open;
    logic data_ok;
    logic fetch_ok;

    // Evaluate the privilege gate and both access-kind rules.
    always_comb begin
        gate_open = is_priv || !auth[AUTH_PRIV_BIT];
        data_ok   = auth[AUTH_WRITE_BIT] || (auth[AUTH_READ_BIT] && !is_store);
        fetch_ok  = auth[AUTH_EXEC_BIT] && !io_type;
        perm_ok   = gate_open && (is_fetch ? fetch_ok : data_ok);
    end
endmodule

// File: rtl/pte_rc_eval.sv
// Reference/change check: the reference flag must be set, and a store
// also needs the change flag. Purely combinational.
module pte_rc_eval (
    input  logic ref_flag,
    input  logic chg_flag,
    input  logic is_store,
    output logic rc_ok
);
    // Combine the two flags with the access kind.
    always_comb begin
        rc_ok = ref_flag && (chg_flag || !is_store);
    end
endmodule

// File: rtl/pte_verdict_stage.sv
// Verdict stage: turns the two check results into one verdict (permission
// first) and presents it either registered or combinationally, chosen by
// REGISTER_OUT. Outputs are zero whenever no result is being presented.
module pte_verdict_stage #(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_valid,
    input  logic perm_ok,
    input  logic rc_ok,
    output logic acc_ok,
    output logic perm_err,
    output logic rc_err,
    output logic chk_done
);
    import pte_chk_pkg::*;

    verdict_t verdict;

    // Pick the verdict; a permission failure hides any RC failure.
    always_comb begin
        if (!perm_ok)     verdict = VERD_PERM;
        else if (!rc_ok)  verdict = VERD_RC;
        else              verdict = VERD_OK;
    end

    generate
        if (REGISTER_OUT) begin : g_reg
            // Capture the verdict on a request; clear it otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_ok   <= 1'b0;
                    perm_err <= 1'b0;
                    rc_err   <= 1'b0;
                    chk_done <= 1'b0;
                end else begin
                    acc_ok   <= chk_valid && (verdict == VERD_OK);
                    perm_err <= chk_valid && (verdict == VERD_PERM);
                    rc_err   <= chk_valid && (verdict == VERD_RC);
                    chk_done <= chk_valid;
                end
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            // Present the verdict in the request cycle.
            always_comb begin
                acc_ok   = chk_valid && (verdict == VERD_OK);
                perm_err = chk_valid && (verdict == VERD_PERM);
                rc_err   = chk_valid && (verdict == VERD_RC);
                chk_done = chk_valid;
            end
        end
    endgenerate
endmodule

// File: rtl/pte_access_check.sv
// Top: leaf page entry access checker. Slices the entry, runs the authority
// and reference/change checks in parallel and hands both to the verdict
// stage. Assumes ENTRY_W covers the reference bit.
module pte_access_check #(
    parameter int ENTRY_W      = 64,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_valid,
    input  logic [ENTRY_W-1:0] pte,
    input  logic               is_priv,
    input  logic               is_fetch,
    input  logic               is_store,
    output logic               acc_ok,
    output logic               perm_err,
    output logic               rc_err,
    output logic               chk_done
);
    import pte_chk_pkg::*;

    localparam int HI_W = ENTRY_W - MIN_ENTRY_W;

    logic perm_ok;
    logic rc_ok;
    logic unused_bits;

    // Bits that take no part in the decision (R9).
    generate
        if (HI_W > 0) begin : g_hi
            assign unused_bits = ^{pte[ENTRY_W-1:MIN_ENTRY_W], pte[6], pte[4]};
        end else begin : g_nohi
            assign unused_bits = pte[6] ^ pte[4];
        end
    endgenerate

    pte_perm_eval u_perm (
        .auth     (pte[AUTH_PRIV_BIT:AUTH_EXEC_BIT]),
        .io_type  (pte[MTYPE_HI_BIT]),
        .is_priv  (is_priv),
        .is_fetch (is_fetch),
        .is_store (is_store),
        .perm_ok  (perm_ok)
    );

    pte_rc_eval u_rc (
        .ref_flag (pte[REF_BIT]),
        .chg_flag (pte[CHG_BIT]),
        .is_store (is_store),
        .rc_ok    (rc_ok)
    );

    pte_verdict_stage #(.REGISTER_OUT(REGISTER_OUT)) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .perm_ok   (perm_ok),
        .rc_ok     (rc_ok),
        .acc_ok    (acc_ok),
        .perm_err  (perm_err),
        .rc_err    (rc_err),
        .chk_done  (chk_done)
    );
endmodule

// File: rtl/pte_access_check_chk.sv
// Checker bound to pte_access_check: keeps its own copy of the request,
// aligned with the result cycle of the chosen form, and checks the outputs
// against it.
module pte_access_check_chk #(
    parameter int ENTRY_W      = 64,
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chk_valid,
    input logic [ENTRY_W-1:0] pte,
    input logic               is_priv,
    input logic               is_fetch,
    input logic               is_store,
    input logic               acc_ok,
    input logic               perm_err,
    input logic               rc_err,
    input logic               chk_done
);
    logic       v_q, priv_q, fetch_q;
    logic [8:0] e_q;
    logic       v_s, priv_s, fetch_s;
    logic [8:0] e_s;
    logic       unused_chk;

    assign unused_chk = is_store ^ ^pte;

    // Delay the request by one cycle for the registered form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= 1'b0;
            priv_q  <= 1'b0;
            fetch_q <= 1'b0;
            e_q     <= '0;
        end else begin
            v_q     <= chk_valid;
            priv_q  <= is_priv;
            fetch_q <= is_fetch;
            e_q     <= pte[8:0];
        end
    end

    // Select the request copy that the current outputs answer.
    always_comb begin
        v_s     = REGISTER_OUT ? v_q     : chk_valid;
        priv_s  = REGISTER_OUT ? priv_q  : is_priv;
        fetch_s = REGISTER_OUT ? fetch_q : is_fetch;
        e_s     = REGISTER_OUT ? e_q     : pte[8:0];
    end

    a_r8_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done == v_s);

    a_r7_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> ($countones({acc_ok, perm_err, rc_err}) == 1));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> ({acc_ok, perm_err, rc_err} == 3'b000));

    a_r2_priv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && !priv_s && e_s[3]) |-> perm_err);

    a_r4_io_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && fetch_s && e_s[5]) |-> perm_err);

    a_r5_ref_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && !e_s[8]) |-> !acc_ok);
endmodule

bind pte_access_check pte_access_check_chk #(
    .ENTRY_W      (ENTRY_W),
    .REGISTER_OUT (REGISTER_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .pte       (pte),
    .is_priv   (is_priv),
    .is_fetch  (is_fetch),
    .is_store  (is_store),
    .acc_ok    (acc_ok),
    .perm_err  (perm_err),
    .rc_err    (rc_err),
    .chk_done  (chk_done)
);

// File: tb/sim_pte_access_check.sv
module sim_pte_access_check;
    localparam int EW = 64;
    localparam int NV = 27;
    // {entry, priv, fetch, store, expected {ok,perm,rc}, requirement number}
    localparam logic [73:0] VEC [NV] = '{
        {64'h184, 1'b0, 1'b0, 1'b0, 3'b100, 4'd3},  // R3 read, load
        {64'h184, 1'b0, 1'b0, 1'b1, 3'b010, 4'd3},  // R3 read only, store
        {64'h182, 1'b0, 1'b0, 1'b1, 3'b100, 4'd3},  // R3 write, store
        {64'h182, 1'b0, 1'b0, 1'b0, 3'b100, 4'd3},  // R3 write grants load
        {64'h180, 1'b0, 1'b0, 1'b0, 3'b010, 4'd3},  // R3 no authority
        {64'h18C, 1'b0, 1'b0, 1'b0, 3'b010, 4'd2},  // R2 user on priv page
        {64'h18C, 1'b1, 1'b0, 1'b0, 3'b100, 4'd2},  // R2 priv load
        {64'h18E, 1'b1, 1'b0, 1'b1, 3'b100, 4'd2},  // R2 priv store
        {64'h189, 1'b1, 1'b1, 1'b0, 3'b100, 4'd2},  // R2 priv fetch
        {64'h189, 1'b0, 1'b1, 1'b0, 3'b010, 4'd2},  // R2 user fetch refused
        {64'h181, 1'b0, 1'b1, 1'b0, 3'b100, 4'd4},  // R4 exec, normal
        {64'h1A1, 1'b0, 1'b1, 1'b0, 3'b010, 4'd4},  // R4 type 10
        {64'h1B1, 1'b0, 1'b1, 1'b0, 3'b010, 4'd4},  // R4 type 11
        {64'h191, 1'b0, 1'b1, 1'b0, 3'b100, 4'd4},  // R4 type 01
        {64'h186, 1'b0, 1'b1, 1'b0, 3'b010, 4'd4},  // R4 no exec bit
        {64'h1A6, 1'b0, 1'b0, 1'b0, 3'b100, 4'd4},  // R4 bit 5 ignored for data
        {64'h084, 1'b0, 1'b0, 1'b0, 3'b001, 4'd5},  // R5 no reference
        {64'h104, 1'b0, 1'b0, 1'b0, 3'b100, 4'd5},  // R5 load needs no change
        {64'h102, 1'b0, 1'b0, 1'b1, 3'b001, 4'd5},  // R5 store needs change
        {64'h002, 1'b0, 1'b0, 1'b1, 3'b001, 4'd5},  // R5 neither flag
        {64'h101, 1'b0, 1'b1, 1'b1, 3'b001, 4'd5},  // R5 applies to fetch
        {64'h004, 1'b0, 1'b0, 1'b1, 3'b010, 4'd6},  // R6 both fail
        {64'h008, 1'b0, 1'b0, 1'b0, 3'b010, 4'd6},  // R6 both fail
        {64'h000, 1'b0, 1'b1, 1'b0, 3'b010, 4'd6},  // R6 both fail, fetch
        {64'hFFFF_FFFF_FFFF_FFC4, 1'b0, 1'b0, 1'b0, 3'b100, 4'd9}, // R9
        {64'hFFFF_FFFF_FFFF_FFC4, 1'b0, 1'b0, 1'b1, 3'b010, 4'd9}, // R9
        {64'hFFFF_FFFF_FFFF_FF51, 1'b0, 1'b1, 1'b0, 3'b100, 4'd9}  // R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_valid = 1'b0;
    logic [EW-1:0] pte = '0;
    logic          is_priv = 1'b0, is_fetch = 1'b0, is_store = 1'b0;
    logic          ok0, pe0, rc0, dn0, ok1, pe1, rc1, dn1;
    int            total = 0;
    int            bad = 0;

    always #4 clk = ~clk;

    pte_access_check #(.ENTRY_W(EW), .REGISTER_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .pte(pte),
        .is_priv(is_priv), .is_fetch(is_fetch), .is_store(is_store),
        .acc_ok(ok0), .perm_err(pe0), .rc_err(rc0), .chk_done(dn0));

    pte_access_check #(.ENTRY_W(EW), .REGISTER_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .pte(pte),
        .is_priv(is_priv), .is_fetch(is_fetch), .is_store(is_store),
        .acc_ok(ok1), .perm_err(pe1), .rc_err(rc1), .chk_done(dn1));

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {ok,perm,rc,done} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: request presented during reset leaves the registered copy idle
        @(negedge clk);
        chk_valid = 1'b1; pte = 64'h184;
        @(negedge clk);
        check("R1 in reset", {ok0, pe0, rc0, dn0}, 4'b0000);
        chk_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {ok0, pe0, rc0, dn0}, 4'b0000);
        check("R7 comb idle", {ok1, pe1, rc1, dn1}, 4'b0000);

        // Vector table, back to back requests
        for (int i = 0; i < NV; i++) begin
            pte = VEC[i][73:10];
            is_priv = VEC[i][9]; is_fetch = VEC[i][8]; is_store = VEC[i][7];
            chk_valid = 1'b1;
            #1;
            check($sformatf("R%0d comb vec %0d", VEC[i][3:0], i),
                  {ok1, pe1, rc1, dn1}, {VEC[i][6:4], 1'b1});
            @(negedge clk);
            check($sformatf("R%0d reg vec %0d", VEC[i][3:0], i),
                  {ok0, pe0, rc0, dn0}, {VEC[i][6:4], 1'b1});
        end

        // R8: single request gives one done pulse, then R7 zeros
        chk_valid = 1'b0;
        @(negedge clk);
        check("R8 pulse ends", {ok0, pe0, rc0, dn0}, 4'b0000);
        pte = 64'h102; is_priv = 1'b0; is_fetch = 1'b0; is_store = 1'b1;
        chk_valid = 1'b1;
        #1;
        check("R8 comb same cycle", {ok1, pe1, rc1, dn1}, 4'b0011);
        check("R8 reg not yet", {ok0, pe0, rc0, dn0}, 4'b0000);
        @(negedge clk);
        chk_valid = 1'b0;
        #1;
        check("R8 reg one cycle later", {ok0, pe0, rc0, dn0}, 4'b0011);
        check("R7 comb idle after", {ok1, pe1, rc1, dn1}, 4'b0000);
        @(negedge clk);
        check("R7 reg idle after pulse", {ok0, pe0, rc0, dn0}, 4'b0000);

        // R1: reset in mid-operation clears the registered result
        chk_valid = 1'b1; pte = 64'h184; is_store = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", {ok0, pe0, rc0, dn0}, 4'b0000);
        chk_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule